// File: doc/BRIEF.md
# Dual-Ranked Host Mailbox Register File

This block holds the mailbox registers between a host bus and an embedded controller processor. There are eight 16-bit slots. Each slot is two physical registers that share one address. The inbound register is written by the host and read by the processor. The outbound register is written by the processor and read by the host. A host read at a slot address therefore never returns what the host last wrote there.

The host issues a command by loading the inbound slots and writing inbound slot 0 last. That write raises a doorbell interrupt toward the processor, and the processor acknowledges it through a control word. The processor posts results, handle-only completions or unsolicited events in the outbound slots. Its write to outbound slot 0 raises the host interrupt, which stays asserted until the host clears it through the same control word address on its own side. Reads on both sides are combinational.

Top module: `host_mbox_regs`

## Requirements
- R1: After reset, every inbound and outbound register reads 0, and both `host_irq_o` and `cpu_irq_o` are low.
- R2: A host write with `host_addr_i` below 8 loads the inbound register of that slot. From the next cycle, the processor reads that value at the same address on `cpu_rdata_o`.
- R3: Host writes never change `host_rdata_o` at a slot address, and processor writes never change `cpu_rdata_o` at a slot address. Each side reads only the register the other side writes.
- R4: A processor write with `cpu_addr_i` below 8 loads the outbound register of that slot. From the next cycle, the host reads that value at the same address.
- R5: A host write to slot 0 sets `cpu_irq_o` in the next cycle. Host writes to slots 1 to 7 leave `cpu_irq_o` unchanged.
- R6: A processor write to address 8 with data bit 0 set clears `cpu_irq_o` in the next cycle. The same write with bit 0 clear has no effect.
- R7: A processor write to slot 0 sets `host_irq_o`. The flag stays high until the host writes address 8 with data bit 0 set.
- R8: When the set event and the clear event of a flag fall in the same cycle, the set wins and the flag is high afterwards.
- R9: A host write and a processor write to the same slot in the same cycle both take effect, each in its own register.
- R10: A read of address 8 on either side returns `{14'b0, cpu_irq_o, host_irq_o}`, with bit 0 holding the host flag and bit 1 the processor flag. Reads of addresses 9 to 15 return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| host_we_i | input | 1 | Host write strobe |
| host_addr_i | input | 4 | Host address: 0 to 7 are slots, 8 is control |
| host_wdata_i | input | 16 | Host write data |
| host_rdata_o | output | 16 | Host read data (outbound slot or status) |
| host_irq_o | output | 1 | Host mailbox interrupt |
| cpu_we_i | input | 1 | Processor write strobe |
| cpu_addr_i | input | 4 | Processor address: 0 to 7 are slots, 8 is control |
| cpu_wdata_i | input | 16 | Processor write data |
| cpu_rdata_o | output | 16 | Processor read data (inbound slot or status) |
| cpu_irq_o | output | 1 | Doorbell interrupt to the processor |

## Verification
The assertions assume that the write strobes and addresses are known after reset. They also assume that a strobe lasts exactly the cycles in which the caller means to write, since every cycle with a strobe high counts as a separate write. The stimulus changes all inputs on the falling edge and holds each strobe for one cycle. It keeps the strobes low between operations, so that stability and hold properties see idle cycles. The same-cycle cases are driven on purpose: both sides on one slot, and set against clear on each flag.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  // control word bit positions
  localparam int unsigned HOST_CLR_BIT = 0;
  localparam int unsigned CPU_ACK_BIT  = 0;
  localparam int unsigned STAT_HOST_BIT = 0;
  localparam int unsigned STAT_CPU_BIT  = 1;
endpackage

// File: rtl/mbox_bank.sv
module mbox_bank #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] regs_q [NUM_SLOTS];

  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                           regs_q[g] <= '0;
      else if (we_i && widx_i == IDX_W'(g))  regs_q[g] <= wdata_i;
    end
  end

  assign rdata_o = regs_q[ridx_i];

  // R2 / R4: write lands in the addressed slot
  a_r2_write_lands: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> regs_q[$past(widx_i)] == $past(wdata_i));
  // R3: no write strobe, no change
  a_r3_idle_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(regs_q[ridx_i]) || $changed(ridx_i));
endmodule

// File: rtl/mbox_flag.sv
module mbox_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q_o <= 1'b0;
    else if (set_i)  q_o <= 1'b1;   // set wins over clear
    else if (clr_i)  q_o <= 1'b0;
  end

  a_r8_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> q_o);
  a_r6_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> !q_o);
  a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> q_o == $past(q_o));
endmodule

// File: rtl/host_mbox_regs.sv
module host_mbox_regs #(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned DATA_W    = 16,
  localparam int unsigned IDX_W    = $clog2(NUM_SLOTS),
  localparam int unsigned ADDR_W   = IDX_W + 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              host_we_i,
  input  logic [ADDR_W-1:0] host_addr_i,
  input  logic [DATA_W-1:0] host_wdata_i,
  output logic [DATA_W-1:0] host_rdata_o,
  output logic              host_irq_o,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  output logic [DATA_W-1:0] cpu_rdata_o,
  output logic              cpu_irq_o
);
  import mbox_pkg::*;

  localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(NUM_SLOTS);

  logic host_slot, cpu_slot, host_ctrl, cpu_ctrl;
  logic [DATA_W-1:0] in_rd, out_rd, status;

  assign host_slot = host_addr_i < CTRL_ADDR;
  assign cpu_slot  = cpu_addr_i  < CTRL_ADDR;
  assign host_ctrl = host_addr_i == CTRL_ADDR;
  assign cpu_ctrl  = cpu_addr_i  == CTRL_ADDR;

  // inbound: host writes, processor reads
  mbox_bank #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_inbound (
    .clk_i, .rst_ni,
    .we_i   (host_we_i && host_slot),
    .widx_i (host_addr_i[IDX_W-1:0]),
    .wdata_i(host_wdata_i),
    .ridx_i (cpu_addr_i[IDX_W-1:0]),
    .rdata_o(in_rd)
  );

  // outbound: processor writes, host reads
  mbox_bank #(.NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W)) u_outbound (
    .clk_i, .rst_ni,
    .we_i   (cpu_we_i && cpu_slot),
    .widx_i (cpu_addr_i[IDX_W-1:0]),
    .wdata_i(cpu_wdata_i),
    .ridx_i (host_addr_i[IDX_W-1:0]),
    .rdata_o(out_rd)
  );

  mbox_flag u_doorbell (
    .clk_i, .rst_ni,
    .set_i(host_we_i && host_addr_i == '0),
    .clr_i(cpu_we_i && cpu_ctrl && cpu_wdata_i[CPU_ACK_BIT]),
    .q_o  (cpu_irq_o)
  );

  mbox_flag u_host_int (
    .clk_i, .rst_ni,
    .set_i(cpu_we_i && cpu_addr_i == '0),
    .clr_i(host_we_i && host_ctrl && host_wdata_i[HOST_CLR_BIT]),
    .q_o  (host_irq_o)
  );

  always_comb begin
    status = '0;
    status[STAT_HOST_BIT] = host_irq_o;
    status[STAT_CPU_BIT]  = cpu_irq_o;
  end

  assign host_rdata_o = host_slot ? out_rd : (host_ctrl ? status : '0);
  assign cpu_rdata_o  = cpu_slot  ? in_rd  : (cpu_ctrl  ? status : '0);

  // R3: a host write never alters what the host reads at a slot
  a_r3_host_no_echo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_we_i && !cpu_we_i && host_slot |=> $stable(host_rdata_o) || $changed(host_addr_i));
  // R5: doorbell only from slot 0
  a_r5_doorbell_src: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cpu_irq_o) |-> $past(host_we_i) && $past(host_addr_i) == '0);
  // R7: host interrupt only drops on host clear
  a_r7_host_clr_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(host_irq_o) |-> $past(host_we_i) && $past(host_ctrl));
endmodule

// File: tb/host_mbox_regs_bench.sv
`timescale 1ns/1ps
module host_mbox_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_we = 1'b0, cpu_we = 1'b0;
  logic [3:0]  host_addr = '0, cpu_addr = '0;
  logic [15:0] host_wdata = '0, cpu_wdata = '0;
  logic [15:0] host_rdata, cpu_rdata;
  logic        host_irq, cpu_irq;
  int          n_run = 0, n_fail = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  host_mbox_regs u_host_mbox_regs (
    .clk_i(clk), .rst_ni(rst_n),
    .host_we_i(host_we), .host_addr_i(host_addr), .host_wdata_i(host_wdata),
    .host_rdata_o(host_rdata), .host_irq_o(host_irq),
    .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
    .cpu_rdata_o(cpu_rdata), .cpu_irq_o(cpu_irq)
  );

  // op: 0 host write, 1 cpu write, 2 check host read, 3 check cpu read
  localparam logic [25:0] VEC [12] = '{
    {2'd0, 4'd1, 16'hA5A5, 4'd2},   // R2
    {2'd3, 4'd1, 16'hA5A5, 4'd2},   // R2
    {2'd2, 4'd1, 16'h0000, 4'd3},   // R3
    {2'd1, 4'd2, 16'h1234, 4'd4},   // R4
    {2'd2, 4'd2, 16'h1234, 4'd4},   // R4
    {2'd3, 4'd2, 16'h0000, 4'd3},   // R3
    {2'd0, 4'd7, 16'hFFFF, 4'd2},
    {2'd3, 4'd7, 16'hFFFF, 4'd2},
    {2'd2, 4'd7, 16'h0000, 4'd3},
    {2'd0, 4'd9, 16'hBEEF, 4'd10},  // R10
    {2'd3, 4'd9, 16'h0000, 4'd10},
    {2'd2, 4'd8, 16'h0000, 4'd5}    // R5: no doorbell from slots 1..7
  };

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic hwe, input logic [3:0] ha, input logic [15:0] hd,
                     input logic cwe, input logic [3:0] ca, input logic [15:0] cd);
    @(negedge clk);
    host_we = hwe; host_addr = ha; host_wdata = hd;
    cpu_we = cwe; cpu_addr = ca; cpu_wdata = cd;
    @(negedge clk);
    host_we = 1'b0; cpu_we = 1'b0;
  endtask

  task automatic hread(input logic [3:0] a);
    host_addr = a; #0.5;
  endtask
  task automatic cread(input logic [3:0] a);
    cpu_addr = a; #0.5;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    hread(4'd0); chk("R1 host slot0", host_rdata, 16'h0);
    cread(4'd5); chk("R1 cpu slot5", cpu_rdata, 16'h0);
    chk("R1 irqs", {14'b0, cpu_irq, host_irq}, 16'h0);

    for (int i = 0; i < 12; i++) begin
      logic [1:0] op; logic [3:0] a; logic [15:0] d; logic [3:0] r;
      {op, a, d, r} = VEC[i];
      case (op)
        2'd0: cyc(1'b1, a, d, 1'b0, 4'd0, 16'h0);
        2'd1: cyc(1'b0, 4'd0, 16'h0, 1'b1, a, d);
        2'd2: begin hread(a); chk($sformatf("R%0d host rd a%0d", r, a), host_rdata, d); end
        default: begin cread(a); chk($sformatf("R%0d cpu rd a%0d", r, a), cpu_rdata, d); end
      endcase
    end

    // R5 doorbell from slot 0
    cyc(1'b1, 4'd0, 16'h0042, 1'b0, 4'd0, 16'h0);
    chk("R5 doorbell", {15'b0, cpu_irq}, 16'h1);
    cread(4'd8); chk("R10 cpu status", cpu_rdata, 16'h0002);
    hread(4'd8); chk("R10 host status", host_rdata, 16'h0002);
    // R6 ack with bit0 clear ignored, then real ack
    cyc(1'b0, 4'd0, 16'h0, 1'b1, 4'd8, 16'hFFFE);
    chk("R6 ack bit0=0 ignored", {15'b0, cpu_irq}, 16'h1);
    cyc(1'b0, 4'd0, 16'h0, 1'b1, 4'd8, 16'h0001);
    chk("R6 ack clears", {15'b0, cpu_irq}, 16'h0);

    // R7 host interrupt holds until host clear
    cyc(1'b0, 4'd0, 16'h0, 1'b1, 4'd0, 16'h00C3);
    repeat (4) @(negedge clk);
    chk("R7 host irq held", {15'b0, host_irq}, 16'h1);
    hread(4'd0); chk("R4 slot0 out", host_rdata, 16'h00C3);
    cyc(1'b1, 4'd8, 16'h0000, 1'b0, 4'd0, 16'h0);
    chk("R7 clr bit0=0 ignored", {15'b0, host_irq}, 16'h1);
    cyc(1'b1, 4'd8, 16'h0001, 1'b0, 4'd0, 16'h0);
    chk("R7 host clr", {15'b0, host_irq}, 16'h0);

    // R8 set and clear in one cycle: set wins (both flags)
    cyc(1'b1, 4'd8, 16'h0001, 1'b1, 4'd0, 16'h0011);
    chk("R8 host set wins", {15'b0, host_irq}, 16'h1);
    cyc(1'b1, 4'd0, 16'h0022, 1'b1, 4'd8, 16'h0001);
    chk("R8 doorbell set wins", {15'b0, cpu_irq}, 16'h1);

    // R9 same slot, same cycle
    cyc(1'b1, 4'd3, 16'h1111, 1'b1, 4'd3, 16'h2222);
    hread(4'd3); chk("R9 host sees outbound", host_rdata, 16'h2222);
    cread(4'd3); chk("R9 cpu sees inbound", cpu_rdata, 16'h1111);

    // R10 out-of-range write changed nothing
    hread(4'd12); chk("R10 unmapped read", host_rdata, 16'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule